// File: doc/BRIEF.md
# Tag-Steered Crypto Stream Router

This block sits between a descriptor-driven stream source and a set of cipher and digest engines. Every input beat carries a 32-bit data word and a 32-bit tag. The router decodes the tag and sends the beat to one of three engine ports: the block cipher engine (port 0), the digest engine (port 1) or a pass-through path (port 2). Each port offers two sub-interfaces, chosen by a tag bit. One takes register writes, with a word address. The other takes stream data, with a data-type code. A last marker from the tag travels with the beat.

The word, the last marker, the data-type code and the register address are broadcast on shared buses. Only the chosen sub-interface of the chosen port sees valid high. The handshake passes straight through with no storage. A beat that names no known engine is taken and thrown away. That event raises a sticky error flag. Over the consecutive words of one register block, the register address steps up by four per word. The tag therefore only needs the block's first offset.

Top module: `tag_stream_router`

## Requirements
- R1: Tag bits [3:0] pick the port. Code 0x1 selects port 0, code 0x3 selects port 1 and code 0xF selects port 2. No other code selects any port.
- R2: When tag bit 4 is 1, the selected port's register-write valid (`out_cfg_valid`) is raised. When it is 0, the stream-data valid (`out_dat_valid`) is raised. Both valids stay low while `in_valid` is low.
- R3: `out_last` equals tag bit 5 of the current beat.
- R4: `out_dtype` equals tag bits [7:6] of the current beat. Examples are 0 for cipher payload or digest message, 1 for header or initial state, 2 for MAC key, and 3 for reference digest.
- R5: `out_cfg_addr` equals tag bits [15:8] plus 4 times k, modulo 256. Here k counts the register-write beats accepted since the current block began. A block begins after reset, after an accepted beat with bit 5 set, and after an accepted stream-data beat. Stalled or dropped beats leave k unchanged.
- R6: For a known code, `in_ready` equals the `out_ready` bit of the selected port and ignores the other ports. Valids of the unselected ports stay low.
- R7: A beat with an unknown engine code sees `in_ready` high and raises no output valid. `err_unknown` goes high at the next clock edge and stays high until reset.
- R8: `out_data` equals `in_data` in the same cycle.
- R9: During and right after reset, `err_unknown` is 0 and k is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 32 | Input data word |
| in_tag | input | 32 | Steering tag of the beat |
| out_cfg_valid | output | 3 | Per-port register-write valid |
| out_dat_valid | output | 3 | Per-port stream-data valid |
| out_ready | input | 3 | Per-port ready |
| out_data | output | 32 | Broadcast data word |
| out_last | output | 1 | Broadcast last marker |
| out_dtype | output | 2 | Broadcast data-type code |
| out_cfg_addr | output | 8 | Broadcast register word address |
| err_unknown | output | 1 | Sticky unknown-engine flag |

## Verification
Decode and steering are purely combinational. A fault there shows on the valid, ready and broadcast ports in the very cycle the beat is presented. The only state is the block word counter and the error flag. A counter that fails to advance or restart shows up as a wrong `out_cfg_addr` on the next register-write beat. A flag that fails to set or to hold shows on `err_unknown` one edge after the dropped beat. The reference model compares every output on every cycle, so both kinds of fault are seen within one beat.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int TAG_W     = 32;
  localparam int ENG_W     = 4;
  localparam int CFG_BIT   = 4;
  localparam int LAST_BIT  = 5;
  localparam int DT_LSB    = 6;
  localparam int DT_W      = 2;
  localparam int OFS_LSB   = 8;
  localparam int OFS_W     = 8;
  localparam int NENG      = 3;
  localparam int ADDR_STEP = 4;
  localparam int IDX_W     = OFS_W - 2;

  typedef struct packed {
    logic [ENG_W-1:0] eng;
    logic             cfg;
    logic             last;
    logic [DT_W-1:0]  dtype;
    logic [OFS_W-1:0] ofs;
  } tag_f_t;

  function automatic tag_f_t split_tag(input logic [TAG_W-1:0] t);
    tag_f_t f;
    f.eng   = t[ENG_W-1:0];
    f.cfg   = t[CFG_BIT];
    f.last  = t[LAST_BIT];
    f.dtype = t[DT_LSB +: DT_W];
    f.ofs   = t[OFS_LSB +: OFS_W];
    return f;
  endfunction

  // engine code owned by port index
  function automatic logic [ENG_W-1:0] eng_code(input int idx);
    case (idx)
      0:       return 4'h1;
      1:       return 4'h3;
      default: return 4'hF;
    endcase
  endfunction

  // word address of the idx-th register word of a block
  function automatic logic [OFS_W-1:0] cfg_addr_at(input logic [OFS_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
    return base + OFS_W'(int'(idx) * ADDR_STEP);
  endfunction
endpackage

// File: rtl/route_tag_decode.sv
module route_tag_decode
  import route_pkg::*;
#(
  parameter int N = NENG
) (
  input  logic [TAG_W-1:0] tag_i,
  output tag_f_t           fld_o,
  output logic [N-1:0]     hit_o,
  output logic             known_o
);
  logic [TAG_W-OFS_LSB-OFS_W-1:0] unused_hi;
  assign unused_hi = tag_i[TAG_W-1:OFS_LSB+OFS_W];

  assign fld_o = split_tag(tag_i);

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit_o[g] = (fld_o.eng == eng_code(g));
  end

  assign known_o = |hit_o;

  always_comb begin
    assert_hit_onehot_R1: assert ($onehot0(hit_o));
  end
endmodule

// File: rtl/route_port_steer.sv
module route_port_steer #(
  parameter int N = 3
) (
  input  logic         in_valid_i,
  input  logic [N-1:0] hit_i,
  input  logic         known_i,
  input  logic         is_cfg_i,
  input  logic [N-1:0] out_ready_i,
  output logic [N-1:0] cfg_valid_o,
  output logic [N-1:0] dat_valid_o,
  output logic         in_ready_o,
  output logic         accept_o,
  output logic         drop_o
);
  logic sel_ready;

  assign sel_ready   = |(hit_i & out_ready_i);
  assign in_ready_o  = known_i ? sel_ready : 1'b1;
  assign cfg_valid_o = (in_valid_i &&  is_cfg_i) ? hit_i : '0;
  assign dat_valid_o = (in_valid_i && !is_cfg_i) ? hit_i : '0;
  assign accept_o    = in_valid_i && known_i && sel_ready;
  assign drop_o      = in_valid_i && !known_i;

  always_comb begin
    assert_one_port_R6: assert ($onehot0({cfg_valid_o, dat_valid_o}));
    assert_handshake_R6: assert (accept_o == |((cfg_valid_o | dat_valid_o) & out_ready_i));
    assert_drop_silent_R7: assert (!drop_o || ((cfg_valid_o | dat_valid_o) == '0));
  end
endmodule

// File: rtl/route_cfg_tracker.sv
module route_cfg_tracker
  import route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             is_cfg_i,
  input  logic             last_i,
  input  logic [OFS_W-1:0] base_i,
  output logic [OFS_W-1:0] addr_o
);
  logic [IDX_W-1:0] word_idx;
  logic             step_ev;
  logic             restart_ev;

  assign step_ev    = accept_i && is_cfg_i && !last_i;
  assign restart_ev = accept_i && !step_ev;

  always_ff @(posedge clk) begin
    if (!rst_n)          word_idx <= '0;
    else if (step_ev)    word_idx <= word_idx + 1'b1;
    else if (restart_ev) word_idx <= '0;
  end

  assign addr_o = cfg_addr_at(base_i, word_idx);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> (word_idx == IDX_W'($past(word_idx) + 1'b1)));
  assert_block_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ev |=> (word_idx == '0));
  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(word_idx));
endmodule

// File: rtl/tag_stream_router.sv
module tag_stream_router
  import route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic [31:0] in_tag,
  output logic [2:0]  out_cfg_valid,
  output logic [2:0]  out_dat_valid,
  input  logic [2:0]  out_ready,
  output logic [31:0] out_data,
  output logic        out_last,
  output logic [1:0]  out_dtype,
  output logic [7:0]  out_cfg_addr,
  output logic        err_unknown
);
  tag_f_t          fld;
  logic [NENG-1:0] hit;
  logic            known;
  logic            accept;
  logic            drop;

  route_tag_decode #(.N(NENG)) u_dec (
    .tag_i  (in_tag),
    .fld_o  (fld),
    .hit_o  (hit),
    .known_o(known)
  );

  route_port_steer #(.N(NENG)) u_steer (
    .in_valid_i (in_valid),
    .hit_i      (hit),
    .known_i    (known),
    .is_cfg_i   (fld.cfg),
    .out_ready_i(out_ready),
    .cfg_valid_o(out_cfg_valid),
    .dat_valid_o(out_dat_valid),
    .in_ready_o (in_ready),
    .accept_o   (accept),
    .drop_o     (drop)
  );

  route_cfg_tracker u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept_i(accept),
    .is_cfg_i(fld.cfg),
    .last_i  (fld.last),
    .base_i  (fld.ofs),
    .addr_o  (out_cfg_addr)
  );

  assign out_data  = in_data;
  assign out_last  = fld.last;
  assign out_dtype = fld.dtype;

  always_ff @(posedge clk) begin
    if (!rst_n)    err_unknown <= 1'b0;
    else if (drop) err_unknown <= 1'b1;
  end

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err_unknown);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_unknown |=> err_unknown);
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_unknown) |-> $past(drop));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ((out_cfg_valid | out_dat_valid) == 3'b000));
endmodule

// File: tb/tag_stream_router_bench.sv
module tag_stream_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [31:0] in_tag = '0;
  logic [2:0]  out_cfg_valid, out_dat_valid;
  logic [2:0]  out_ready = 3'b111;
  logic [31:0] out_data;
  logic        out_last;
  logic [1:0]  out_dtype;
  logic [7:0]  out_cfg_addr;
  logic        err_unknown;

  int checks = 0;
  int fails = 0;
  int m_cnt = 0;
  bit m_err = 1'b0;
  bit run = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tag_stream_router u_tag_stream_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_tag(in_tag), .out_cfg_valid(out_cfg_valid),
    .out_dat_valid(out_dat_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_dtype(out_dtype), .out_cfg_addr(out_cfg_addr),
    .err_unknown(err_unknown)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int port_of(input logic [3:0] code);
    if (code == 4'h1) return 0;
    if (code == 4'h3) return 1;
    if (code == 4'hF) return 2;
    return -1;
  endfunction

  function automatic logic [31:0] mk_tag(input logic [3:0] eng, input bit cfg, input bit last,
                                         input logic [1:0] dt, input logic [7:0] ofs);
    return {16'h0, ofs, dt, last, cfg, eng};
  endfunction

  // reference model: compare every cycle, then advance state for the coming edge
  always @(negedge clk) begin
    if (run) begin
      int p;
      bit known, rdy, fire;
      logic [2:0] ecfg, edat;
      p = port_of(in_tag[3:0]);
      known = (p >= 0);
      ecfg = 3'b000;
      edat = 3'b000;
      if (in_valid && known) begin
        if (in_tag[4]) ecfg = 3'(1 << p);
        else           edat = 3'(1 << p);
      end
      rdy = known ? out_ready[p] : 1'b1;
      chk("R1 R2 cfg valid", 64'(out_cfg_valid), 64'(ecfg));
      chk("R1 R2 data valid", 64'(out_dat_valid), 64'(edat));
      chk("R6 in_ready", 64'(in_ready), 64'(rdy));
      chk("R3 last", 64'(out_last), 64'(in_tag[5]));
      chk("R4 dtype", 64'(out_dtype), 64'(in_tag[7:6]));
      chk("R5 cfg addr", 64'(out_cfg_addr), 64'((int'(in_tag[15:8]) + 4 * m_cnt) % 256));
      chk("R8 data", 64'(out_data), 64'(in_data));
      chk("R7 err flag", 64'(err_unknown), 64'(m_err));
      fire = in_valid && rdy;
      if (fire && !known) m_err = 1'b1;
      if (fire && known) begin
        if (in_tag[4] && !in_tag[5]) m_cnt = m_cnt + 1;
        else                         m_cnt = 0;
      end
    end
  end

  task automatic step(input bit v, input logic [31:0] tag, input logic [31:0] d,
                      input logic [2:0] rdy);
    @(posedge clk);
    #1;
    in_valid = v;
    in_tag = tag;
    in_data = d;
    out_ready = rdy;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 reset err", 64'(err_unknown), 64'd0);
      chk("R9 reset valids", 64'({out_cfg_valid, out_dat_valid}), 64'd0);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    run = 1'b1;
    @(negedge clk);
    chk("R9 reset block counter", 64'(out_cfg_addr), 64'(in_tag[15:8]));
    // cipher register block of three words from 0x28, last on the third
    step(1, mk_tag(4'h1, 1, 0, 2'd0, 8'h28), 32'hA0, 3'b111);
    step(1, mk_tag(4'h1, 1, 0, 2'd0, 8'h28), 32'hA1, 3'b111);
    step(1, mk_tag(4'h1, 1, 1, 2'd0, 8'h28), 32'hA2, 3'b111);
    // new block restarts at its own base
    step(1, mk_tag(4'h1, 1, 0, 2'd0, 8'h08), 32'hB0, 3'b111);
    step(1, mk_tag(4'h1, 1, 0, 2'd0, 8'h08), 32'hB1, 3'b111);
    // data beat ends the block (R5)
    step(1, mk_tag(4'h1, 0, 0, 2'd1, 8'h00), 32'hC0, 3'b111);
    step(1, mk_tag(4'h1, 1, 0, 2'd0, 8'h00), 32'hC1, 3'b111);
    // backpressure on the selected port only (R6), counter holds
    step(1, mk_tag(4'h1, 1, 0, 2'd0, 8'h00), 32'hD0, 3'b110);
    step(1, mk_tag(4'h1, 1, 0, 2'd0, 8'h00), 32'hD0, 3'b110);
    step(1, mk_tag(4'h1, 1, 1, 2'd0, 8'h00), 32'hD0, 3'b001);
    // digest data types
    for (int t = 0; t < 4; t++)
      step(1, mk_tag(4'h3, 0, t[0], 2'(t), 8'h00), 32'hE0 + t, 3'b111);
    step(1, mk_tag(4'hF, 0, 1, 2'd0, 8'h00), 32'hF00D, 3'b111);
    step(1, mk_tag(4'hF, 1, 0, 2'd0, 8'hFC), 32'hF1, 3'b111);
    step(1, mk_tag(4'hF, 1, 1, 2'd0, 8'hFC), 32'hF2, 3'b111);
    step(0, mk_tag(4'h2, 0, 0, 2'd0, 8'h00), 32'h0, 3'b111);
    // unknown code dropped (R7), then stays set over idle
    step(1, mk_tag(4'h2, 1, 0, 2'd0, 8'h10), 32'hBAD, 3'b000);
    step(0, 32'h0, 32'h0, 3'b111);
    step(0, 32'h0, 32'h0, 3'b111);
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] e;
      int pick;
      pick = int'($urandom_range(0, 9));
      e = (pick < 3) ? 4'h1 : (pick < 6) ? 4'h3 : (pick < 9) ? 4'hF : 4'($urandom);
      step(($urandom_range(0, 4) != 0),
           mk_tag(e, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                  2'($urandom), 8'($urandom)),
           $urandom, 3'($urandom));
    end
    step(0, 32'h0, 32'h0, 3'b111);
    @(posedge clk);
    #1;
    run = 1'b0;
    finished = 1'b1;
    summary();
  end
endmodule